// File: doc/BRIEF.md
# Ethernet receive status word generator

This block watches one received Ethernet frame at a time and, when the frame ends, produces a seven-bit status word that summarises it. Bytes arrive one per clock while `rx_dv` is high. The end of the frame is the first cycle in which `rx_dv` is low after a high cycle. In that end cycle the receiver also presents the frame length in bytes, the number of leftover bits in the last partial byte, and the pass/fail result of its CRC checker. This block does not compute the CRC. It also does not store status words; a downstream queue takes them when `stat_vld` pulses.

Inside the frame, the block counts bytes for a receive watchdog, captures the two-byte length/type field, and records whether a receive error or a late collision was seen. Several status flags gate one another. A late collision hides the dribble flag. A short (runt) frame cannot be marked as a typed frame. The CRC flag is forced clear whenever its meaning is lost.

Top module: `rx_status_gen`

## Requirements
- R1: `stat_vld` is high for exactly one cycle, one clock after the end-of-frame cycle (the cycle with `rx_dv` low following `rx_dv` high). `stat_word` holds its value until the next such pulse.
- R2: Bit 6 is set when `late_col` was high in any cycle of the frame in which `rx_dv` was high.
- R3: Bit 5 is set when the length/type field is greater than 1500. The field is byte 12 (upper) and byte 13 (lower), counted from 0 in the order received. Values of 1500 or less clear bit 5.
- R4: Bit 5 is 0 when `frm_len` is below 14, whatever bytes 12 and 13 last held.
- R5: Bit 4 is set when more than `WDOG_LIMIT` (default 2048) bytes were received in the frame. Exactly `WDOG_LIMIT` bytes leaves it clear.
- R6: Bit 3 is set when `rx_err` was high in any cycle of the frame in which `rx_dv` was high.
- R7: Bit 2 is set from `tail_bits` when `mode_10m` is 0 and `tail_bits` equals 4, or when `mode_10m` is 1 and `tail_bits` is at least 3. Other values clear it.
- R8: Bit 2 is 0 whenever bit 6 is set.
- R9: Bit 1 is set when `crc_ok` is 0 at the end of the frame, or when bit 3 is set.
- R10: Bit 1 is forced to 0 for a runt frame (`frm_len` below 14), a late-collision frame, or a frame whose watchdog expired.
- R11: Bit 0 is always 0. Error and collision history is cleared between frames, so a flag seen in one frame never appears in the status of the next.
- R12: After reset, `stat_vld` is 0 and `stat_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_10m | input | 1 | 1 selects the 10 Mbps dribble rule; 0 selects the MII rule |
| rx_dv | input | 1 | One valid receive byte this cycle; its fall marks the end of the frame |
| rx_byte | input | 8 | Receive byte |
| rx_err | input | 1 | Receive error indication |
| late_col | input | 1 | Collision seen after the collision window |
| frm_len | input | LEN_W | Frame length in bytes, valid in the end cycle |
| tail_bits | input | 3 | Leftover bits in the last partial byte, valid in the end cycle |
| crc_ok | input | 1 | CRC check passed, valid in the end cycle |
| stat_word | output | 7 | Status word, bits 6..0 |
| stat_vld | output | 1 | One-cycle pulse when a new status word is presented |

## Verification
The end-of-frame cycle is registered once, so the status word and `stat_vld` appear one clock after the first low `rx_dv` cycle. The bench drives inputs at falling edges. After the end cycle it waits one rising edge and samples at the next falling edge, where it expects the pulse and the word. One clock later it checks that the pulse has dropped and the word is unchanged. Each frame scenario computes its expected word from the requirement rules. The scenarios use the stimulus parameters only, never the design's state.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int STAT_W     = 7;
    localparam int RUNT_BYTES = 14;
    localparam int TYPE_MIN   = 1500;
    localparam int LT_HI_IDX  = 12;
    localparam int LT_LO_IDX  = 13;

    typedef struct packed {
        logic              dv;
        logic              err_seen;
        logic              col_seen;
        logic [STAT_W-1:0] word;
        logic              vld;
    } rxs_state_t;
endpackage

// File: rtl/rxs_byte_ctr.sv
module rxs_byte_ctr #(
    parameter int WDOG_LIMIT = 2048,
    localparam int CW = $clog2(WDOG_LIMIT + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_dv,
    output logic [CW-1:0] cnt,
    output logic          over
);
    localparam logic [CW-1:0] CAP = CW'(WDOG_LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!rx_dv)
            cnt_d = '0;
        else if (cnt_q == CAP)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign over = (cnt_q > CW'(WDOG_LIMIT));

    a_r5_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CAP);
    a_r5_clears_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_dv |=> (cnt_q == '0));
endmodule

// File: rtl/rxs_lentype.sv
module rxs_lentype #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_dv,
    input  logic [7:0]    rx_byte,
    input  logic [CW-1:0] idx,
    output logic [15:0]   lentype
);
    import rxs_pkg::*;

    logic [15:0] lt_d, lt_q;

    always_comb begin
        lt_d = lt_q;
        if (rx_dv && idx == CW'(LT_HI_IDX)) lt_d[15:8] = rx_byte;
        if (rx_dv && idx == CW'(LT_LO_IDX)) lt_d[7:0]  = rx_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lt_q <= '0;
        else        lt_q <= lt_d;
    end

    assign lentype = lt_q;

    a_r3_field_only_changes_on_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_dv |=> $stable(lt_q));
endmodule

// File: rtl/rx_status_gen.sv
module rx_status_gen #(
    parameter int WDOG_LIMIT = 2048,
    parameter int LEN_W      = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_10m,
    input  logic             rx_dv,
    input  logic [7:0]       rx_byte,
    input  logic             rx_err,
    input  logic             late_col,
    input  logic [LEN_W-1:0] frm_len,
    input  logic [2:0]       tail_bits,
    input  logic             crc_ok,
    output logic [6:0]       stat_word,
    output logic             stat_vld
);
    import rxs_pkg::*;

    localparam int CW = $clog2(WDOG_LIMIT + 2);

    logic [CW-1:0] byte_idx;
    logic          wd_over;
    logic [15:0]   lentype;

    rxs_byte_ctr #(.WDOG_LIMIT(WDOG_LIMIT)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_dv (rx_dv),
        .cnt   (byte_idx),
        .over  (wd_over)
    );

    rxs_lentype #(.CW(CW)) u_lt (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_dv   (rx_dv),
        .rx_byte (rx_byte),
        .idx     (byte_idx),
        .lentype (lentype)
    );

    rxs_state_t s_d, s_q;
    logic frame_end, runt, drib, col, err;

    always_comb begin
        frame_end = s_q.dv && !rx_dv;
        runt      = (frm_len < LEN_W'(RUNT_BYTES));
        col       = s_q.col_seen;
        err       = s_q.err_seen;
        drib      = mode_10m ? (tail_bits >= 3'd3) : (tail_bits == 3'd4);

        s_d          = s_q;
        s_d.dv       = rx_dv;
        s_d.vld      = frame_end;
        s_d.err_seen = frame_end ? 1'b0 : (s_q.err_seen || (rx_dv && rx_err));
        s_d.col_seen = frame_end ? 1'b0 : (s_q.col_seen || (rx_dv && late_col));
        if (frame_end) begin
            s_d.word[6] = col;
            s_d.word[5] = !runt && (lentype > 16'(TYPE_MIN));
            s_d.word[4] = wd_over;
            s_d.word[3] = err;
            s_d.word[2] = drib && !col;
            s_d.word[1] = (!crc_ok || err) && !runt && !col && !wd_over;
            s_d.word[0] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stat_word = s_q.word;
    assign stat_vld  = s_q.vld;

    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.vld |=> !s_q.vld);
    a_r1_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.word) |-> s_q.vld);
    a_r8_no_dribble_with_col: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.vld |-> !(s_q.word[6] && s_q.word[2]));
    a_r10_crc_gated: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.vld && (s_q.word[6] || s_q.word[4]) |-> !s_q.word[1]);
    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.word[0]);
endmodule

// File: tb/rx_status_gen_tb.sv
module rx_status_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_10m = 1'b0;
    logic        rx_dv = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_err = 1'b0;
    logic        late_col = 1'b0;
    logic [13:0] frm_len = '0;
    logic [2:0]  tail_bits = '0;
    logic        crc_ok = 1'b1;
    logic [6:0]  stat_word;
    logic        stat_vld;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    rx_status_gen u_dut (
        .clk(clk), .rst_n(rst_n), .mode_10m(mode_10m), .rx_dv(rx_dv),
        .rx_byte(rx_byte), .rx_err(rx_err), .late_col(late_col),
        .frm_len(frm_len), .tail_bits(tail_bits), .crc_ok(crc_ok),
        .stat_word(stat_word), .stat_vld(stat_vld)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] expect_word(int n, int flen, int lt, bit err,
                                               bit col, int tail, bit ok, bit m10);
        logic [6:0] w = '0;
        bit runt = (flen < 14);
        bit wd   = (n > 2048);
        bit dr   = m10 ? (tail >= 3) : (tail == 4);
        w[6] = col;
        w[5] = !runt && (lt > 1500);
        w[4] = wd;
        w[3] = err;
        w[2] = dr && !col;
        w[1] = (!ok || err) && !runt && !col && !wd;
        return w;
    endfunction

    // Sends a frame of n bytes, then checks word and pulse timing.
    task automatic frame(string req, int n, int flen, int lt, int err_at,
                         int col_at, int tail, bit ok, bit m10);
        logic [6:0] exp;
        exp = expect_word(n, flen, lt, err_at >= 0, col_at >= 0, tail, ok, m10);
        @(negedge clk);
        mode_10m = m10;
        for (int i = 0; i < n; i++) begin
            rx_dv    = 1'b1;
            rx_byte  = (i == 12) ? 8'(lt >> 8) : (i == 13) ? 8'(lt) : 8'(i);
            rx_err   = (i == err_at);
            late_col = (i == col_at);
            @(negedge clk);
        end
        rx_dv = 1'b0; rx_err = 1'b0; late_col = 1'b0;
        frm_len = 14'(flen); tail_bits = 3'(tail); crc_ok = ok;
        @(negedge clk);
        check({req, " R1 pulse"}, {7'b0, stat_vld}, 8'd1);
        check({req, " word R11"}, {1'b0, stat_word}, {1'b0, exp});
        @(negedge clk);
        crc_ok = 1'b1; tail_bits = '0;
        check({req, " R1 pulse drop"}, {7'b0, stat_vld}, 8'd0);
        check({req, " R1 hold"}, {1'b0, stat_word}, {1'b0, exp});
    endtask

    task automatic t_reset();
        check("R12 vld", {7'b0, stat_vld}, 8'd0);
        check("R12 word", {1'b0, stat_word}, 8'd0);
    endtask

    task automatic t_lentype();
        frame("R3 type 0x0800", 64, 64, 16'h0800, -1, -1, 0, 1, 0);
        frame("R3 R9 len 64 crc bad", 64, 64, 64, -1, -1, 0, 0, 0);
        frame("R3 boundary 1500", 60, 60, 1500, -1, -1, 0, 1, 0);
        frame("R3 boundary 1501", 60, 60, 1501, -1, -1, 0, 1, 0);
    endtask

    task automatic t_runt();
        frame("R4 R10 runt", 10, 10, 1501, -1, -1, 0, 0, 0);
        frame("R4 runt 13", 13, 13, 1501, -1, -1, 0, 0, 0);
    endtask

    task automatic t_err();
        frame("R6 R9 rx_err", 64, 64, 16'h0800, 20, -1, 0, 1, 0);
        frame("R11 clean after err", 64, 64, 16'h0800, -1, -1, 0, 1, 0);
    endtask

    task automatic t_dribble();
        frame("R7 mii tail4", 64, 64, 100, -1, -1, 4, 1, 0);
        frame("R7 mii tail3", 64, 64, 100, -1, -1, 3, 1, 0);
        frame("R7 10m tail3", 64, 64, 100, -1, -1, 3, 1, 1);
        frame("R7 10m tail2", 64, 64, 100, -1, -1, 2, 1, 1);
    endtask

    task automatic t_col();
        frame("R2 R8 R10 late col", 64, 64, 16'h0800, -1, 40, 4, 0, 0);
        frame("R11 clean after col", 64, 64, 16'h0800, -1, -1, 4, 1, 0);
    endtask

    task automatic t_wdog();
        frame("R5 R10 2049 bytes", 2049, 2049, 16'h0800, -1, -1, 0, 0, 0);
        frame("R5 2048 bytes", 2048, 2048, 16'h0800, -1, -1, 0, 0, 0);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lentype();
        t_runt();
        t_err();
        t_dribble();
        t_col();
        t_wdog();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule